// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block brings a DDR SDRAM device from power-on to a usable state. After reset it holds the clock enable low through a programmable stabilization interval. It then raises the clock enable while driving no-operation commands. Next it walks the device through the mandatory bring-up commands: a precharge of every bank, an extended mode write that turns the DLL on, and a mode write that resets the DLL. These are followed by a second precharge of every bank, a programmable number of auto-refresh commands, and a final mode write that clears the DLL reset bit. Every delay between commands is a parameter counted in clock cycles.

The DLL lock interval starts when the DLL reset command is issued. It runs concurrently with the commands that follow. The ready flag rises only when both of these have elapsed: the lock interval, and the command gap that follows the final mode write. A memory controller holds its own traffic until the ready flag is seen.

Parameters also supply the mode word, which holds CAS latency, burst type and burst length. A parameter selects whether the pin outputs are registered.

Top module: `ddr_boot_seq`

## Requirements
- R1: From the cycle reset is released, `mem_cke` is low for T_STAB cycles, plus one cycle when REG_OUT=1. During that time the pins carry NOP with address and bank zero, and `boot_done` is low.
- R2: Once `mem_cke` rises it stays high. NOP is driven for T_CKE_NOP cycles before the first command.
- R3: A precharge-all is encoded as CS_n/RAS_n/CAS_n/WE_n = 0/0/1/0, with address bit 10 high, every other address bit low and bank zero. The next command follows exactly T_RP cycles later.
- R4: The first mode command, which enables the DLL, is encoded 0/0/0/0 with bank value 1 (bank bit 0 high) and every address bit low.
- R5: The second mode command, which resets the DLL, is encoded 0/0/0/0 with bank 0 and address equal to MODE_WORD with bit 8 forced high. It starts the T_DLL lock interval.
- R6: Every mode command is followed by exactly T_MRD cycles before the next command. All cycles in that gap are NOP.
- R7: The second precharge-all comes T_MRD cycles after the DLL reset. T_RP cycles later, N_REF auto-refresh commands are issued, encoded 0/0/0/1 with address and bank zero and spaced T_RFC cycles apart.
- R8: T_RFC cycles after the last refresh, a final mode command is issued with bank 0 and address equal to MODE_WORD with bit 8 forced low.
- R9: `boot_done` rises exactly at the later of two points: T_MRD cycles after the final mode command, or T_DLL cycles after the DLL reset. Once high it stays high, with `mem_cke` high and NOP on the pins.
- R10: Asserting reset at any point returns the outputs at once to the R1 state. Releasing reset restarts the whole sequence.
- R11: Every cycle that is not one of the commands above carries NOP (0/1/1/1) with address and bank zero.
- R12: REG_OUT=1 delays every output by exactly one cycle relative to REG_OUT=0. The relative timing between outputs is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_cke | output | 1 | Clock enable to the device |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | ROW_W | Address bus |
| mem_ba | output | BANK_W | Bank address |
| boot_done | output | 1 | Device ready for normal commands |

## Verification
The bench runs two configurations. In one, the DLL lock interval outlasts the final mode gap. In the other, the final gap ends last. A design that waited on only one of the two would raise the ready flag early in one of these runs.

Every cycle is compared against a timeline computed from the parameters. A gap counted one cycle short or long therefore shows up as a command on the wrong cycle. A swapped address encoding shows up as a wrong value on the bus: bit 8 on the two mode writes, bit 10 on precharge, or bank bit 0 on the DLL enable.

Reset is also pulsed at random points inside the sequence. A sequencer that resumed from stale state instead of restarting would emit commands during the stabilization window.

// File: rtl/ddr_boot_pkg.sv
package ddr_boot_pkg;

   typedef enum logic [3:0] {
      ST_STAB,
      ST_WAKE,
      ST_PRE_A,
      ST_GAP_A,
      ST_EXT,
      ST_GAP_B,
      ST_DLLRST,
      ST_GAP_C,
      ST_PRE_B,
      ST_GAP_D,
      ST_REF,
      ST_GAP_E,
      ST_MODE,
      ST_SETTLE,
      ST_READY
   } boot_st_e;

   typedef enum logic [1:0] {
      K_NOP,
      K_PRE,
      K_REF,
      K_MRS
   } cmd_kind_e;

   typedef struct packed {
      logic cs_n;
      logic ras_n;
      logic cas_n;
      logic we_n;
   } cmd_pins_t;

   localparam cmd_pins_t PINS_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

   function automatic cmd_pins_t kind_pins(input cmd_kind_e k);
      cmd_pins_t p;
      unique case (k)
         K_PRE:   p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
         K_REF:   p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
         K_MRS:   p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
         default: p = PINS_NOP;
      endcase
      return p;
   endfunction

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ddr_boot_timer.sv
module ddr_boot_timer #(
   parameter int W       = 8,
   parameter int RST_VAL = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= W'(RST_VAL);
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/ddr_boot_dll_wait.sv
module ddr_boot_dll_wait #(
   parameter int T_DLL = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic locked
);

   localparam int LW = $clog2(T_DLL + 1);

   logic [LW-1:0] cnt;
   logic          armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= LW'(T_DLL - 1);
         armed <= 1'b0;
      end else if (start) begin
         cnt   <= LW'(T_DLL - 2);
         armed <= 1'b1;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign locked = armed && (cnt == '0);

endmodule

// File: rtl/ddr_boot_drive.sv
module ddr_boot_drive
   import ddr_boot_pkg::*;
#(
   parameter int              ROW_W     = 13,
   parameter int              BANK_W    = 2,
   parameter logic [ROW_W-1:0] MODE_WORD = 13'h0062,
   parameter bit              REG_OUT   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  boot_st_e          st,
   output logic              cke,
   output cmd_pins_t         pins,
   output logic [ROW_W-1:0]  addr,
   output logic [BANK_W-1:0] ba,
   output logic              done
);

   localparam int              DLL_BIT  = 8;
   localparam int              AP_BIT   = 10;
   localparam logic [ROW_W-1:0] DLL_MASK = ROW_W'(1) << DLL_BIT;
   localparam logic [ROW_W-1:0] AP_MASK  = ROW_W'(1) << AP_BIT;

   cmd_kind_e         kind;
   logic              d_cke;
   logic              d_done;
   cmd_pins_t         d_pins;
   logic [ROW_W-1:0]  d_addr;
   logic [BANK_W-1:0] d_ba;

   always_comb begin
      kind   = K_NOP;
      d_addr = '0;
      d_ba   = '0;
      unique case (st)
         ST_PRE_A, ST_PRE_B: begin
            kind   = K_PRE;
            d_addr = AP_MASK;
         end
         ST_EXT: begin
            kind = K_MRS;
            d_ba = BANK_W'(1);
         end
         ST_DLLRST: begin
            kind   = K_MRS;
            d_addr = MODE_WORD | DLL_MASK;
         end
         ST_MODE: begin
            kind   = K_MRS;
            d_addr = MODE_WORD & ~DLL_MASK;
         end
         ST_REF: begin
            kind = K_REF;
         end
         default: begin
            kind = K_NOP;
         end
      endcase
   end

   assign d_pins = kind_pins(kind);
   assign d_cke  = (st != ST_STAB);
   assign d_done = (st == ST_READY);

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cke  <= 1'b0;
               pins <= PINS_NOP;
               addr <= '0;
               ba   <= '0;
               done <= 1'b0;
            end else begin
               cke  <= d_cke;
               pins <= d_pins;
               addr <= d_addr;
               ba   <= d_ba;
               done <= d_done;
            end
         end
      end else begin : g_comb
         assign cke  = d_cke;
         assign pins = d_pins;
         assign addr = d_addr;
         assign ba   = d_ba;
         assign done = d_done;
      end
   endgenerate

endmodule

// File: rtl/ddr_boot_seq.sv
module ddr_boot_seq
   import ddr_boot_pkg::*;
#(
   parameter int              ROW_W     = 13,
   parameter int              BANK_W    = 2,
   parameter int              T_STAB    = 25000,
   parameter int              T_CKE_NOP = 1,
   parameter int              T_RP      = 3,
   parameter int              T_MRD     = 2,
   parameter int              T_RFC     = 10,
   parameter int              N_REF     = 2,
   parameter int              T_DLL     = 200,
   parameter logic [ROW_W-1:0] MODE_WORD = 13'h0062,
   parameter bit              REG_OUT   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              mem_cke,
   output logic              mem_cs_n,
   output logic              mem_ras_n,
   output logic              mem_cas_n,
   output logic              mem_we_n,
   output logic [ROW_W-1:0]  mem_addr,
   output logic [BANK_W-1:0] mem_ba,
   output logic              boot_done
);

   localparam int GAP_MAX = max_of(max_of(max_of(T_STAB, T_CKE_NOP), max_of(T_RP, T_MRD)), T_RFC);
   localparam int TW      = $clog2(GAP_MAX + 1);
   localparam int RCW     = $clog2(N_REF + 1);

   localparam logic [TW-1:0] LD_WAKE = TW'(T_CKE_NOP - 1);
   localparam logic [TW-1:0] LD_RP   = TW'(T_RP - 2);
   localparam logic [TW-1:0] LD_MRD  = TW'(T_MRD - 2);
   localparam logic [TW-1:0] LD_RFC  = TW'(T_RFC - 2);

   generate
      if (ROW_W < 11) begin : g_bad_row
         $error("ddr_boot_seq: ROW_W must reach address bit 10");
      end
      if (BANK_W < 1) begin : g_bad_bank
         $error("ddr_boot_seq: BANK_W must be at least 1");
      end
      if (N_REF < 2) begin : g_bad_nref
         $error("ddr_boot_seq: N_REF must be at least 2");
      end
      if (T_RP < 2 || T_MRD < 2 || T_RFC < 2) begin : g_bad_gap
         $error("ddr_boot_seq: command gaps must be at least 2 cycles");
      end
      if (T_STAB < 1 || T_CKE_NOP < 1) begin : g_bad_wake
         $error("ddr_boot_seq: stabilization and wake counts must be positive");
      end
      if (T_DLL < 2) begin : g_bad_dll
         $error("ddr_boot_seq: T_DLL must be at least 2");
      end
   endgenerate

   boot_st_e         st, nxt;
   logic             t_load, t_zero;
   logic [TW-1:0]    t_val;
   logic             dll_go, dll_locked;
   logic             ref_inc;
   logic [RCW-1:0]   ref_cnt;
   cmd_pins_t        pins;

   ddr_boot_timer #(
      .W       (TW),
      .RST_VAL (T_STAB - 1)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .zero     (t_zero)
   );

   ddr_boot_dll_wait #(
      .T_DLL (T_DLL)
   ) u_dll (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (dll_go),
      .locked (dll_locked)
   );

   always_comb begin
      nxt     = st;
      t_load  = 1'b0;
      t_val   = '0;
      dll_go  = 1'b0;
      ref_inc = 1'b0;
      unique case (st)
         ST_STAB: if (t_zero) begin
            nxt    = ST_WAKE;
            t_load = 1'b1;
            t_val  = LD_WAKE;
         end
         ST_WAKE:  if (t_zero) nxt = ST_PRE_A;
         ST_PRE_A: begin
            nxt    = ST_GAP_A;
            t_load = 1'b1;
            t_val  = LD_RP;
         end
         ST_GAP_A: if (t_zero) nxt = ST_EXT;
         ST_EXT: begin
            nxt    = ST_GAP_B;
            t_load = 1'b1;
            t_val  = LD_MRD;
         end
         ST_GAP_B: if (t_zero) nxt = ST_DLLRST;
         ST_DLLRST: begin
            nxt    = ST_GAP_C;
            t_load = 1'b1;
            t_val  = LD_MRD;
            dll_go = 1'b1;
         end
         ST_GAP_C: if (t_zero) nxt = ST_PRE_B;
         ST_PRE_B: begin
            nxt    = ST_GAP_D;
            t_load = 1'b1;
            t_val  = LD_RP;
         end
         ST_GAP_D: if (t_zero) nxt = ST_REF;
         ST_REF: begin
            nxt     = ST_GAP_E;
            t_load  = 1'b1;
            t_val   = LD_RFC;
            ref_inc = 1'b1;
         end
         ST_GAP_E: if (t_zero) nxt = (ref_cnt == RCW'(N_REF)) ? ST_MODE : ST_REF;
         ST_MODE: begin
            nxt    = ST_SETTLE;
            t_load = 1'b1;
            t_val  = LD_MRD;
         end
         ST_SETTLE: if (t_zero && dll_locked) nxt = ST_READY;
         ST_READY:  nxt = ST_READY;
         default:   nxt = ST_STAB;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_STAB;
         ref_cnt <= '0;
      end else begin
         st <= nxt;
         if (ref_inc) ref_cnt <= ref_cnt + 1'b1;
      end
   end

   ddr_boot_drive #(
      .ROW_W     (ROW_W),
      .BANK_W    (BANK_W),
      .MODE_WORD (MODE_WORD),
      .REG_OUT   (REG_OUT)
   ) u_drive (
      .clk   (clk),
      .rst_n (rst_n),
      .st    (st),
      .cke   (mem_cke),
      .pins  (pins),
      .addr  (mem_addr),
      .ba    (mem_ba),
      .done  (boot_done)
   );

   assign mem_cs_n  = pins.cs_n;
   assign mem_ras_n = pins.ras_n;
   assign mem_cas_n = pins.cas_n;
   assign mem_we_n  = pins.we_n;

endmodule

// File: rtl/ddr_boot_chk.sv
module ddr_boot_chk #(
   parameter int ROW_W  = 13,
   parameter int BANK_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cke,
   input logic              cs_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic [ROW_W-1:0]  addr,
   input logic [BANK_W-1:0] ba,
   input logic              done
);

   logic [3:0] pn;
   logic       is_nop, is_pre, is_ref, is_mrs;

   assign pn     = {cs_n, ras_n, cas_n, we_n};
   assign is_nop = (pn == 4'b0111);
   assign is_pre = (pn == 4'b0010);
   assign is_ref = (pn == 4'b0001);
   assign is_mrs = (pn == 4'b0000);

   AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      is_nop || is_pre || is_ref || is_mrs);                                // R11
   AST_CKE_LOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |-> (is_nop && !done));                                         // R1
   AST_CKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cke |=> cke);                                                        // R2
   AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
      is_pre |-> (addr[10] && ba == '0));                                  // R3
   AST_DLL_ENABLE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (is_mrs && ba == BANK_W'(1)) |-> (addr == '0));                      // R4
   AST_MRS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      is_mrs |=> is_nop);                                                  // R6
   AST_REF_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      is_ref |-> (addr == '0 && ba == '0));                                // R7
   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);                                                      // R9
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cke && is_nop));                                           // R9
   AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      is_nop |-> (addr == '0 && ba == '0));                                // R11

endmodule

bind ddr_boot_seq ddr_boot_chk #(
   .ROW_W  (ROW_W),
   .BANK_W (BANK_W)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .cke   (mem_cke),
   .cs_n  (mem_cs_n),
   .ras_n (mem_ras_n),
   .cas_n (mem_cas_n),
   .we_n  (mem_we_n),
   .addr  (mem_addr),
   .ba    (mem_ba),
   .done  (boot_done)
);

// File: tb/sim_ddr_boot_seq.sv
`timescale 1ns/1ps
module sim_ddr_boot_seq;

   typedef struct packed {
      logic        cke;
      logic [3:0]  pins;
      logic [12:0] addr;
      logic [1:0]  ba;
      logic        done;
   } obs_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   int   sel = 0;
   int   vectors = 0;
   int   fails = 0;
   int   cyc = 0;
   bit   fin = 1'b0;

   always #4 clk = ~clk;

   logic        c0, cs0, ra0, ca0, we0, d0;
   logic [12:0] a0;
   logic [1:0]  b0;
   logic        c1, cs1, ra1, ca1, we1, d1;
   logic [12:0] a1;
   logic [1:0]  b1;

   // Configuration 0: DLL lock interval ends last, registered outputs
   ddr_boot_seq #(
      .ROW_W(13), .BANK_W(2), .T_STAB(30), .T_CKE_NOP(2), .T_RP(3), .T_MRD(2),
      .T_RFC(5), .N_REF(2), .T_DLL(200), .MODE_WORD(13'h0032), .REG_OUT(1'b1)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .mem_cke(c0), .mem_cs_n(cs0), .mem_ras_n(ra0),
      .mem_cas_n(ca0), .mem_we_n(we0), .mem_addr(a0), .mem_ba(b0), .boot_done(d0)
   );

   // Configuration 1: final mode gap ends last, combinational outputs
   ddr_boot_seq #(
      .ROW_W(13), .BANK_W(2), .T_STAB(12), .T_CKE_NOP(1), .T_RP(2), .T_MRD(3),
      .T_RFC(4), .N_REF(3), .T_DLL(6), .MODE_WORD(13'h0062), .REG_OUT(1'b0)
   ) u1 (
      .clk(clk), .rst_n(rst_n), .mem_cke(c1), .mem_cs_n(cs1), .mem_ras_n(ra1),
      .mem_cas_n(ca1), .mem_we_n(we1), .mem_addr(a1), .mem_ba(b1), .boot_done(d1)
   );

   obs_t obs;
   always_comb begin
      if (sel == 0) obs = '{cke: c0, pins: {cs0, ra0, ca0, we0}, addr: a0, ba: b0, done: d0};
      else          obs = '{cke: c1, pins: {cs1, ra1, ca1, we1}, addr: a1, ba: b1, done: d1};
   end

   localparam obs_t RST_OBS = '{cke: 1'b0, pins: 4'b0111, addr: 13'h0, ba: 2'b00, done: 1'b0};

   // Timeline of one configuration, from the requirements
   function automatic int done_cycle(input int s);
      int lat, ts, tn, trp, tmrd, trfc, nref, tdll, pre1, mrsr, mrsf;
      if (s == 0) begin lat = 1; ts = 30; tn = 2; trp = 3; tmrd = 2; trfc = 5; nref = 2; tdll = 200; end
      else        begin lat = 0; ts = 12; tn = 1; trp = 2; tmrd = 3; trfc = 4; nref = 3; tdll = 6;   end
      pre1 = ts + tn + lat;
      mrsr = pre1 + trp + tmrd;
      mrsf = mrsr + tmrd + trp + nref * trfc;
      return ((mrsf + tmrd) > (mrsr + tdll)) ? (mrsf + tmrd) : (mrsr + tdll);
   endfunction

   function automatic obs_t expect_at(input int s, input int k, output string tag);
      int lat, ts, tn, trp, tmrd, trfc, nref, tdll;
      int pre1, emrs, mrsr, pre2, ref0, mrsf, dn;
      logic [12:0] md;
      obs_t e;
      if (s == 0) begin lat = 1; ts = 30; tn = 2; trp = 3; tmrd = 2; trfc = 5; nref = 2; tdll = 200; md = 13'h0032; end
      else        begin lat = 0; ts = 12; tn = 1; trp = 2; tmrd = 3; trfc = 4; nref = 3; tdll = 6;   md = 13'h0062; end
      pre1 = ts + tn + lat;               // R12: lat shifts every event
      emrs = pre1 + trp;
      mrsr = emrs + tmrd;
      pre2 = mrsr + tmrd;
      ref0 = pre2 + trp;
      mrsf = ref0 + nref * trfc;
      dn   = done_cycle(s);
      e = '{cke: (k >= ts + lat), pins: 4'b0111, addr: 13'h0, ba: 2'b00, done: (k >= dn)};
      tag = (k < ts + lat) ? "R1" : ((k < pre1) ? "R2" : "R11");
      if ((k > emrs && k < emrs + tmrd) || (k > mrsr && k < mrsr + tmrd) || (k > mrsf && k < mrsf + tmrd))
         tag = "R6";
      if (k >= dn) tag = "R9";
      if (k == pre1 || k == pre2) begin
         e.pins = 4'b0010; e.addr = 13'h0400; tag = (k == pre1) ? "R3" : "R7";
      end else if (k == emrs) begin
         e.pins = 4'b0000; e.ba = 2'b01; tag = "R4";
      end else if (k == mrsr) begin
         e.pins = 4'b0000; e.addr = md | 13'h0100; tag = "R5";
      end else if (k >= ref0 && k < mrsf && ((k - ref0) % trfc) == 0) begin
         e.pins = 4'b0001; tag = "R7";
      end else if (k == mrsf) begin
         e.pins = 4'b0000; e.addr = md & ~13'h0100; tag = "R8";
      end
      return e;
   endfunction

   task automatic check(input obs_t act, input obs_t exp, input string tag, input int k);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s cfg%0d cycle %0d: actual cke=%b pins=%b addr=%h ba=%b done=%b expected cke=%b pins=%b addr=%h ba=%b done=%b",
                  tag, sel, k, act.cke, act.pins, act.addr, act.ba, act.done,
                  exp.cke, exp.pins, exp.addr, exp.ba, exp.done);
      end
   endtask

   // Hold reset, check the idle state, then release on a falling edge
   task automatic reset_and_release(input int hold);
      rst_n = 1'b0;
      #1;
      check(obs, RST_OBS, "R10", -1);
      repeat (hold) @(negedge clk);
      check(obs, RST_OBS, "R1", -1);
      rst_n = 1'b1;
   endtask

   task automatic run_full(input int s);
      string tag;
      obs_t  e;
      sel = s;
      @(negedge clk);
      reset_and_release(int'($urandom_range(2, 5)));
      for (int k = 0; k <= done_cycle(s) + 4; k++) begin
         #1;
         e = expect_at(s, k, tag);
         check(obs, e, tag, k);
         @(negedge clk);
      end
   endtask

   // Reset part way through, then confirm a clean restart (R10)
   task automatic run_abort(input int s, input int stop);
      string tag;
      obs_t  e;
      sel = s;
      @(negedge clk);
      reset_and_release(2);
      for (int k = 0; k < stop; k++) begin
         #1;
         e = expect_at(s, k, tag);
         check(obs, e, tag, k);
         @(negedge clk);
      end
      rst_n = 1'b0;
      #1;
      check(obs, RST_OBS, "R10", stop);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc >= 150000 && !fin) begin
         fin = 1'b1;
         fails++;
         $display("FAIL watchdog: actual cycle %0d, expected end before 150000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'd4711);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      run_full(0);
      run_full(1);
      for (int i = 0; i < 6; i++) begin
         int s;
         s = i % 2;
         run_abort(s, int'($urandom_range(1, done_cycle(s) - 1)));
         run_full(s);
      end
      // Directed: abort exactly at the DLL reset cycles and one cycle before done
      run_abort(0, 38);
      run_full(0);
      run_abort(1, 37);
      run_full(1);
      if (!fin) begin
         fin = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule